// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block links one narrow A port to two narrow B lanes. In the A-to-B direction, each B lane has its own storage register. A lane loads the A word when its own active-low load enable was sampled low at the previous clock edge. If the two enables are asserted on successive cycles, two A words that arrive one after another end up side by side and form one double-width word across both lanes.

In the B-to-A direction there is a single return register. It captures either lane-1 or lane-2 input data, according to a registered select, and drives that value onto A for a whole cycle.

Every control input passes through a register before it acts. This covers the select, both load enables and the three active-low output enables. A control sampled at one edge therefore governs the data capture at the next edge. A registered output enable switches its port's drive at the edge that samples it. Tri-state is modelled as a data output plus a drive-enable flag for each port. A synchronous reset clears all data, turns every drive off and makes every control inactive.

Top module: `bus_exchanger`

## Requirements
- R1: When `ld1_n` is sampled low at edge N, lane-1 (`b1_q`) holds the `a_i` value present at edge N+1. It appears on `b1_q` after that edge.
- R2: When `ld2_n` is sampled low at edge N, lane-2 (`b2_q`) holds the `a_i` value present at edge N+1. Lane-2 is independent of lane-1.
- R3: A lane whose load enable was sampled high at edge N keeps its value through edge N+1, whatever `a_i` does.
- R4: If lane-1 is enabled one cycle and lane-2 the next, `{b2_q,b1_q}` equals `{second word, first word}`. With the opposite order it equals `{first word, second word}`.
- R5: If both load enables are sampled low at the same edge, both lanes load the same A word at the next edge.
- R6: At every edge, `a_q` captures `b1_i` if `pick_i` was sampled 0 at the previous edge, and `b2_i` if it was sampled 1.
- R7: Each output enable (`a_oe_n`, `b1_oe_n`, `b2_oe_n`) is active low and is registered. Its drive flag is the inverse of the enable value sampled at the most recent edge.
- R8: A synchronous reset clears `a_q`, `b1_q` and `b2_q` and deasserts all three drive flags. After reset, no lane loads and the select is 0 until new controls are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | W | A-port input data toward the lanes |
| b1_i | input | W | Lane-1 input data toward A |
| b2_i | input | W | Lane-2 input data toward A |
| pick_i | input | 1 | Return source: 0 picks lane-1, 1 picks lane-2 |
| ld1_n | input | 1 | Lane-1 load enable, active low |
| ld2_n | input | 1 | Lane-2 load enable, active low |
| a_oe_n | input | 1 | A-port output enable, active low |
| b1_oe_n | input | 1 | Lane-1 output enable, active low |
| b2_oe_n | input | 1 | Lane-2 output enable, active low |
| a_q | output | W | Return register value for A |
| a_drv | output | 1 | A drive flag |
| b1_q | output | W | Lane-1 register value |
| b1_drv | output | 1 | Lane-1 drive flag |
| b2_q | output | W | Lane-2 register value |
| b2_drv | output | 1 | Lane-2 drive flag |

## Verification
The bench builds the block with the default word width of 12. At this width the distinct 12-bit patterns make every lane and the return path identify their source word without ambiguity. All-ones words are used to show that reset clears every bit. Both enable orders, simultaneous enables, select toggles and a reset in mid-run are compared against an independent cycle model.

// File: rtl/bx_pkg.sv
package bx_pkg;

  typedef enum logic {
    SRC_LANE1 = 1'b0,
    SRC_LANE2 = 1'b1
  } src_e;

  typedef struct packed {
    src_e       pick;
    logic [1:0] ld_n;
    logic       a_oe_n;
    logic [1:0] b_oe_n;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{pick: SRC_LANE1, ld_n: 2'b11, a_oe_n: 1'b1, b_oe_n: 2'b11};

  function automatic logic drive_of(input logic oe_n);
    return ~oe_n;
  endfunction

endpackage

// File: rtl/bx_ctrl_sync.sv
module bx_ctrl_sync
  import bx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl_d,
  output ctrl_t ctrl_q
);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_IDLE;
    else     ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/bx_lane_reg.sv
module bx_lane_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic load_ev;
  assign load_ev = ~ld_n;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_ev) q <= d;
  end

  // R3
  lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> $stable(q));

  // R1
  lane_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> (q == $past(d)));

endmodule

// File: rtl/bx_return_path.sv
module bx_return_path
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  src_e         src,
  input  logic [W-1:0] from1,
  input  logic [W-1:0] from2,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] pick_word(input src_e s, input logic [W-1:0] w1,
                                             input logic [W-1:0] w2);
    return (s == SRC_LANE2) ? w2 : w1;
  endfunction

  logic [W-1:0] picked;
  assign picked = pick_word(src, from1, from2);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= picked;
  end

  // R6
  a_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q == (($past(src) == SRC_LANE2) ? $past(from2) : $past(from1))));

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b1_i,
  input  logic [W-1:0] b2_i,
  input  logic         pick_i,
  input  logic         ld1_n,
  input  logic         ld2_n,
  input  logic         a_oe_n,
  input  logic         b1_oe_n,
  input  logic         b2_oe_n,
  output logic [W-1:0] a_q,
  output logic         a_drv,
  output logic [W-1:0] b1_q,
  output logic         b1_drv,
  output logic [W-1:0] b2_q,
  output logic         b2_drv
);

  localparam int LANES = 2;

  ctrl_t ctrl_d, ctrl_q;
  logic [LANES-1:0][W-1:0] lane_q;
  logic [LANES-1:0]        lane_load;
  logic [LANES-1:0]        lane_drv;

  assign ctrl_d.pick   = src_e'(pick_i);
  assign ctrl_d.ld_n   = {ld2_n, ld1_n};
  assign ctrl_d.a_oe_n = a_oe_n;
  assign ctrl_d.b_oe_n = {b2_oe_n, b1_oe_n};

  bx_ctrl_sync u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .ctrl_d (ctrl_d),
    .ctrl_q (ctrl_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_load[i] = ~ctrl_q.ld_n[i];
    assign lane_drv[i]  = drive_of(ctrl_q.b_oe_n[i]);

    bx_lane_reg #(.W(W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .ld_n (ctrl_q.ld_n[i]),
      .d    (a_i),
      .q    (lane_q[i])
    );
  end

  bx_return_path #(.W(W)) u_ret (
    .clk   (clk),
    .rst   (rst),
    .src   (ctrl_q.pick),
    .from1 (b1_i),
    .from2 (b2_i),
    .q     (a_q)
  );

  assign a_drv  = drive_of(ctrl_q.a_oe_n);
  assign b1_q   = lane_q[0];
  assign b2_q   = lane_q[1];
  assign b1_drv = lane_drv[0];
  assign b2_drv = lane_drv[1];

  // R7
  a_drv_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (a_drv == !$past(a_oe_n)));

  // R7
  b_drv_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({b2_drv, b1_drv} == ~$past({b2_oe_n, b1_oe_n})));

  // R5
  same_word_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_load == 2'b11) |=> (b1_q == b2_q));

  // R2
  lane2_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ld2_n |=> ##1 (b2_q == $past(a_i)));

endmodule

// File: tb/bus_exchanger_tb_top.sv
module bus_exchanger_tb_top;
  localparam int W = 12;
  localparam int NV = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [W-1:0] a_i, b1_i, b2_i;
  logic pick_i, ld1_n, ld2_n, a_oe_n, b1_oe_n, b2_oe_n;
  logic [W-1:0] a_q, b1_q, b2_q;
  logic a_drv, b1_drv, b2_drv;

  bus_exchanger #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_i(a_i), .b1_i(b1_i), .b2_i(b2_i), .pick_i(pick_i),
    .ld1_n(ld1_n), .ld2_n(ld2_n), .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n),
    .a_q(a_q), .a_drv(a_drv), .b1_q(b1_q), .b1_drv(b1_drv), .b2_q(b2_q), .b2_drv(b2_drv)
  );

  // stimulus: {a, b1, b2, pick, ld1_n, ld2_n, a_oe_n, b1_oe_n, b2_oe_n}
  localparam logic [41:0] TBL [NV] = '{
    {12'h111, 12'hAAA, 12'h555, 6'b0_01_000},
    {12'h222, 12'hAA1, 12'h551, 6'b1_10_000},
    {12'h333, 12'hAA2, 12'h552, 6'b0_11_011},
    {12'h444, 12'hAA3, 12'h553, 6'b1_00_101},
    {12'h555, 12'hAA4, 12'h554, 6'b1_11_110},
    {12'h666, 12'hAA5, 12'h555, 6'b0_10_111},
    {12'h777, 12'hAA6, 12'h556, 6'b0_01_000},
    {12'h888, 12'hAA7, 12'h557, 6'b1_11_000},
    {12'h999, 12'hAA8, 12'h558, 6'b0_11_100},
    {12'hABC, 12'hAA9, 12'h559, 6'b1_11_000}
  };

  int vec_n = 0;
  int miss_n = 0;

  logic [W-1:0] m_l1, m_l2, m_a;
  logic m_pick, m_ld1, m_ld2, m_oea, m_oeb1, m_oeb2;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (act !== exp) begin
      miss_n++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_l1 = '0; m_l2 = '0; m_a = '0;
      m_pick = 1'b0; m_ld1 = 1'b1; m_ld2 = 1'b1;
      m_oea = 1'b1; m_oeb1 = 1'b1; m_oeb2 = 1'b1;
    end else begin
      if (!m_ld1) m_l1 = a_i;
      if (!m_ld2) m_l2 = a_i;
      m_a = m_pick ? b2_i : b1_i;
      m_pick = pick_i; m_ld1 = ld1_n; m_ld2 = ld2_n;
      m_oea = a_oe_n; m_oeb1 = b1_oe_n; m_oeb2 = b2_oe_n;
    end
  endtask

  task automatic compare_all();
    check("R1 lane1 data", 32'(b1_q), 32'(m_l1));
    check("R2 lane2 data", 32'(b2_q), 32'(m_l2));
    check("R6 return data", 32'(a_q), 32'(m_a));
    check("R7 drive flags", 32'({a_drv, b1_drv, b2_drv}), 32'({~m_oea, ~m_oeb1, ~m_oeb2}));
  endtask

  task automatic cycle(input logic r, input logic [41:0] v);
    rst = r;
    {a_i, b1_i, b2_i, pick_i, ld1_n, ld2_n, a_oe_n, b1_oe_n, b2_oe_n} = v;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    miss_n++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end

  initial begin
    cycle(1'b1, {12'hFFF, 12'hFFF, 12'hFFF, 6'b1_00_000});
    cycle(1'b1, {12'hFFF, 12'hFFF, 12'hFFF, 6'b1_00_000});
    // R8 reset state
    check("R8 reset data", 32'({a_q, b1_q, b2_q}), 32'd0);
    check("R8 reset drive", 32'({a_drv, b1_drv, b2_drv}), 32'd0);

    for (int i = 0; i < NV; i++) cycle(1'b0, TBL[i]);

    // R4 lane-1 first, then lane-2
    cycle(1'b0, {12'h000, 12'h0, 12'h0, 6'b0_01_000});
    cycle(1'b0, {12'h1A1, 12'h0, 12'h0, 6'b0_10_000});
    cycle(1'b0, {12'h2B2, 12'h0, 12'h0, 6'b0_11_000});
    check("R4 wide word forward", 32'({b2_q, b1_q}), 32'({12'h2B2, 12'h1A1}));

    // R4 lane-2 first, then lane-1
    cycle(1'b0, {12'h000, 12'h0, 12'h0, 6'b0_10_000});
    cycle(1'b0, {12'h3C3, 12'h0, 12'h0, 6'b0_01_000});
    cycle(1'b0, {12'h4D4, 12'h0, 12'h0, 6'b0_11_000});
    check("R4 wide word reverse", 32'({b2_q, b1_q}), 32'({12'h3C3, 12'h4D4}));

    // R5 both lanes at once
    cycle(1'b0, {12'h000, 12'h0, 12'h0, 6'b0_00_000});
    cycle(1'b0, {12'h5E5, 12'h0, 12'h0, 6'b0_11_000});
    check("R5 same word", 32'({b2_q, b1_q}), 32'({12'h5E5, 12'h5E5}));

    // R3 hold while A changes
    cycle(1'b0, {12'h0F0, 12'h0, 12'h0, 6'b0_11_000});
    cycle(1'b0, {12'hF0F, 12'h0, 12'h0, 6'b0_11_000});
    check("R3 hold", 32'({b2_q, b1_q}), 32'({12'h5E5, 12'h5E5}));

    // R6 select toggle
    cycle(1'b0, {12'h0, 12'h123, 12'h456, 6'b1_11_000});
    cycle(1'b0, {12'h0, 12'h789, 12'hABC, 6'b0_11_000});
    check("R6 pick lane2", 32'(a_q), 32'(12'hABC));
    cycle(1'b0, {12'h0, 12'hDEF, 12'h321, 6'b0_11_000});
    check("R6 pick lane1", 32'(a_q), 32'(12'hDEF));

    // R8 mid-run reset with enables low
    cycle(1'b1, {12'hFFF, 12'hFFF, 12'hFFF, 6'b1_00_000});
    check("R8 mid reset data", 32'({a_q, b1_q, b2_q}), 32'd0);
    check("R8 mid reset drive", 32'({a_drv, b1_drv, b2_drv}), 32'd0);
    // R7 first edge after reset samples enables
    cycle(1'b0, {12'hFFF, 12'hFFF, 12'hFFF, 6'b1_11_010});
    check("R7 drive after reset", 32'({a_drv, b1_drv, b2_drv}), 32'(3'b101));
    // R8 select and loads inactive after reset
    check("R8 post reset state", 32'({a_q, b1_q, b2_q}), 32'({12'hFFF, 12'h000, 12'h000}));

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end

endmodule